// File: doc/BRIEF.md
# Serial Port Interrupt Collector Register Bank

This block is the global register bank of a multi-port serial controller. Each serial core below it raises one interrupt-request line. The bank samples these lines every clock into a status word. It ANDs the status with a per-port enable mask and drives one registered, level-sensitive interrupt output that is high while any enabled port is requesting.

Software never writes an enable mask directly. Each mask has one register that sets bits and a second register that clears them. A bit is changed only where the written word holds a one. Reading the set register returns the mask, and reading the clear register returns its bitwise inverse. A second mask, for wake interrupts, follows the same rules but never affects the interrupt output.

The bank also offers a fixed identification word and a read-only port-count word. Register accesses use a word address, a four-lane byte-enable, write data, a write strobe and a registered read-data bus. The parameter `NUM_PORTS` must lie in 1..16; other values stop elaboration.

Top module: `sio_irq_bank`

## Requirements
- R1: Word offset 0x00 reads 0x00070002 and word offset 0x04 reads `NUM_PORTS`.
- R2: A write to offset 0x0C ORs the write data into the interrupt-enable mask. A write to offset 0x14 ORs the write data into the wake mask.
- R3: A write to offset 0x10 clears each interrupt-enable bit where the write data is 1. A write to offset 0x18 clears each wake-mask bit where the write data is 1. All other mask bits keep their value.
- R4: Offset 0x0C reads the interrupt-enable mask and offset 0x10 reads its inverse. Offset 0x14 reads the wake mask and offset 0x18 reads its inverse.
- R5: Offset 0x08 reads the status word. Status bit n equals request input n as sampled at the previous clock edge. Bits at and above `NUM_PORTS` read 0.
- R6: `irq` is a register. After each edge it equals the OR over all bits of (status AND interrupt-enable), using the values that both registers hold after that same edge.
- R7: The wake mask has no effect on `irq`.
- R8: Writes to offsets 0x00, 0x04 and 0x08, to undefined offsets and to addresses at or above `WIN_BASE` change no register. Reads at undefined offsets and at addresses at or above `WIN_BASE` return 0.
- R9: An access is decoded only when `be` is 4'b1111 and the address bits [1:0] are 00. Any other access reads 0 and leaves every mask unchanged when written.
- R10: While `rst` is high at an edge, status, both masks, `irq` and `rdata` become 0.
- R11: `rdata` is registered. After an edge it holds the value that the addressed register had before that edge, whatever a write at the same edge does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NUM_PORTS | Per-port interrupt request levels |
| addr | input | ADDR_W | Byte address of the register access |
| be | input | 4 | Byte-lane enables; a full access uses 4'b1111 |
| we | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the address presented at the previous edge |
| irq | output | 1 | Level interrupt, high while any enabled port requests |

## Verification
The masks are first built up with overlapping set words and then trimmed with clear words. This separates an OR-update from a plain overwrite, and a selective clear from a full clear. Request patterns cover three cases: requests on enabled ports only, requests on masked ports only, and requests together with a full wake mask. These show that `irq` follows the enable mask alone and rises or falls one edge after the cause. The bench also uses partial byte enables, misaligned addresses, writes to read-only words, holes in the map and the port window. These show that only full, aligned accesses to the writable words touch state. A reference model, updated on each clock, is compared with `irq` and `rdata` every cycle.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] IDENT_WORD = 32'h0007_0002;

  // word index order equals the address map (index = offset / 4)
  typedef enum logic [2:0] {
    SEL_IDENT    = 3'd0,
    SEL_COUNT    = 3'd1,
    SEL_STATUS   = 3'd2,
    SEL_IEN_SET  = 3'd3,
    SEL_IEN_CLR  = 3'd4,
    SEL_WAKE_SET = 3'd5,
    SEL_WAKE_CLR = 3'd6,
    SEL_NONE     = 3'd7
  } reg_sel_e;

  localparam int unsigned N_MASKS = 2;  // 0: interrupt enable, 1: wake
endpackage

// File: rtl/sio_irq_decode.sv
module sio_irq_decode
  import sio_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned WIN_BASE = 'h1000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  output reg_sel_e          sel
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             full_word;
  logic             below_win;
  logic [IDX_W-1:0] idx;

  assign full_word = (be == 4'b1111) && (addr[1:0] == 2'b00);
  assign below_win = ({{(32-ADDR_W){1'b0}}, addr} < WIN_BASE);
  assign idx       = addr[ADDR_W-1:2];

  always_comb begin
    sel = SEL_NONE;
    if (full_word && below_win && (idx < IDX_W'(7)))
      sel = reg_sel_e'(idx[2:0]);
  end
endmodule

// File: rtl/sio_irq_mask.sv
module sio_irq_mask #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] mask_d
);
  logic [W-1:0] set_bits;
  logic [W-1:0] clr_bits;

  assign set_bits = set_we ? wdata : '0;
  assign clr_bits = clr_we ? wdata : '0;
  assign mask_d   = (mask_q | set_bits) & ~clr_bits;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_d;
  end

  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= 1'b1;
  end

  p_set_or_r2: assert property (@(posedge clk) disable iff (rst)
    seen_q && $past(set_we) |-> mask_q == ($past(mask_q) | $past(wdata)));

  p_clr_sel_r3: assert property (@(posedge clk) disable iff (rst)
    seen_q && $past(clr_we) |-> mask_q == ($past(mask_q) & ~$past(wdata)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    seen_q && !$past(set_we) && !$past(clr_we) |-> $stable(mask_q));
endmodule

// File: rtl/sio_irq_status.sv
module sio_irq_status #(
  parameter int unsigned NUM_PORTS = 16,
  parameter int unsigned W         = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] req,
  input  logic [W-1:0]         en_d,
  output logic [W-1:0]         sts_q,
  output logic                 irq_q
);
  logic [W-1:0] sts_d;

  generate
    if (NUM_PORTS < W) begin : g_pad
      assign sts_d = {{(W-NUM_PORTS){1'b0}}, req};
    end else begin : g_full
      assign sts_d = req[W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      irq_q <= |(sts_d & en_d);
    end
  end

  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= 1'b1;
  end

  p_sts_follow_r5: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> sts_q[NUM_PORTS-1:0] == $past(req));

  p_irq_level_r6: assert property (@(posedge clk) disable iff (rst)
    seen_q && ($past(req) == '0) |-> !irq_q);
endmodule

// File: rtl/sio_irq_bank.sv
module sio_irq_bank
  import sio_irq_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 16,
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned WIN_BASE  = 'h1000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PORTS-1:0]  req,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [3:0]            be,
  input  logic                  we,
  input  logic [WORD_W-1:0]     wdata,
  output logic [WORD_W-1:0]     rdata,
  output logic                  irq
);
  localparam int unsigned MAX_PORTS = 16;
  localparam logic [WORD_W-1:0] COUNT_WORD = WORD_W'(NUM_PORTS);

  generate
    if (NUM_PORTS < 1 || NUM_PORTS > MAX_PORTS) begin : g_bad_cfg
      $error("sio_irq_bank: NUM_PORTS out of range 1..16");
    end
  endgenerate

  reg_sel_e sel;

  sio_irq_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_dec (
    .addr (addr),
    .be   (be),
    .sel  (sel)
  );

  logic [N_MASKS-1:0] set_we;
  logic [N_MASKS-1:0] clr_we;
  logic [WORD_W-1:0]  mask_q [N_MASKS];
  logic [WORD_W-1:0]  mask_d [N_MASKS];

  assign set_we[0] = we && (sel == SEL_IEN_SET);
  assign clr_we[0] = we && (sel == SEL_IEN_CLR);
  assign set_we[1] = we && (sel == SEL_WAKE_SET);
  assign clr_we[1] = we && (sel == SEL_WAKE_CLR);

  generate
    for (genvar g = 0; g < N_MASKS; g++) begin : g_mask
      sio_irq_mask #(.W(WORD_W)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .set_we (set_we[g]),
        .clr_we (clr_we[g]),
        .wdata  (wdata),
        .mask_q (mask_q[g]),
        .mask_d (mask_d[g])
      );
    end
  endgenerate

  logic [WORD_W-1:0] sts_q;

  sio_irq_status #(.NUM_PORTS(NUM_PORTS), .W(WORD_W)) u_sts (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .en_d  (mask_d[0]),
    .sts_q (sts_q),
    .irq_q (irq)
  );

  logic [WORD_W-1:0] rd_mux;
  logic [WORD_W-1:0] wake_next_unused;
  assign wake_next_unused = mask_d[1];

  always_comb begin
    unique case (sel)
      SEL_IDENT:    rd_mux = IDENT_WORD;
      SEL_COUNT:    rd_mux = COUNT_WORD;
      SEL_STATUS:   rd_mux = sts_q;
      SEL_IEN_SET:  rd_mux = mask_q[0];
      SEL_IEN_CLR:  rd_mux = ~mask_q[0];
      SEL_WAKE_SET: rd_mux = mask_q[1];
      SEL_WAKE_CLR: rd_mux = ~mask_q[1];
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= 1'b1;
  end

  p_irq_and_r6: assert property (@(posedge clk) disable iff (rst)
    irq == |(sts_q & mask_q[0]));

  p_wake_free_r7: assert property (@(posedge clk) disable iff (rst)
    seen_q && $stable(sts_q) && $stable(mask_q[0]) |-> $stable(irq));

  p_partial_zero_r9: assert property (@(posedge clk) disable iff (rst)
    seen_q && ($past(be) != 4'b1111) |-> rdata == '0);

  p_ident_r1: assert property (@(posedge clk) disable iff (rst)
    seen_q && $past(addr) == '0 && $past(be) == 4'b1111 |-> rdata == IDENT_WORD);
endmodule

// File: tb/sio_irq_bank_test.sv
module sio_irq_bank_test;
  localparam int NP = 12;
  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] req = '0;
  logic [AW-1:0] addr = '0;
  logic [3:0]    be = 4'hF;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  sio_irq_bank #(.NUM_PORTS(NP), .ADDR_W(AW), .WIN_BASE('h1000)) uut (
    .clk(clk), .rst(rst), .req(req), .addr(addr), .be(be),
    .we(we), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // reference model
  logic [31:0] m_sts = '0, m_en = '0, m_wk = '0, m_rd = '0;
  logic        m_irq = 1'b0;

  always @(posedge clk) begin
    logic ok;
    int   off;
    if (rst) begin
      m_sts = '0; m_en = '0; m_wk = '0; m_rd = '0; m_irq = 1'b0;
    end else begin
      off = int'(addr);
      ok  = (be == 4'hF) && (off % 4 == 0) && (off < 'h1000);
      m_rd = '0;
      if (ok) begin
        case (off)
          'h00: m_rd = 32'h0007_0002;
          'h04: m_rd = NP;
          'h08: m_rd = m_sts;
          'h0C: m_rd = m_en;
          'h10: m_rd = ~m_en;
          'h14: m_rd = m_wk;
          'h18: m_rd = ~m_wk;
          default: m_rd = '0;
        endcase
        if (we) begin
          case (off)
            'h0C: m_en = m_en | wdata;
            'h10: m_en = m_en & ~wdata;
            'h14: m_wk = m_wk | wdata;
            'h18: m_wk = m_wk & ~wdata;
            default: ;
          endcase
        end
      end
      m_sts = 32'(req);
      m_irq = (m_sts & m_en) != 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model (R6 irq, R11 read data)
  always @(negedge clk) begin
    if (!rst) begin
      chk("R6 model irq", 32'(irq), 32'(m_irq));
      chk("R11 model rdata", rdata, m_rd);
    end
  end

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] b = 4'hF);
    @(negedge clk);
    addr = AW'(a); wdata = d; be = b; we = 1'b1;
    @(negedge clk);
    we = 1'b0; be = 4'hF;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag, input logic [3:0] b = 4'hF);
    @(negedge clk);
    addr = AW'(a); be = b; we = 1'b0;
    @(negedge clk);
    chk(tag, rdata, exp);
    be = 4'hF;
  endtask

  task automatic drive_req(input logic [NP-1:0] v, input logic exp_irq, input string tag);
    @(negedge clk);
    req = v;
    @(negedge clk);
    chk(tag, 32'(irq), 32'(exp_irq));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 irq after reset", 32'(irq), 32'h0);
    rd('h08, 32'h0, "R10 status after reset");
    rd('h0C, 32'h0, "R10 enable after reset");
    rd('h18, 32'hFFFF_FFFF, "R10 wake inverse after reset");
    // R1 constants
    rd('h00, 32'h0007_0002, "R1 ident");
    rd('h04, NP, "R1 count");
    // R2 / R3 / R4 mask rules
    wr('h0C, 32'h0000_0005);
    wr('h0C, 32'h0000_0802);
    rd('h0C, 32'h0000_0807, "R2 enable OR");
    wr('h10, 32'h0000_0003);
    rd('h0C, 32'h0000_0804, "R3 enable selective clear");
    rd('h10, 32'hFFFF_F7FB, "R4 enable inverse readback");
    wr('h14, 32'hA000_0001);
    wr('h18, 32'h2000_0000);
    rd('h14, 32'h8000_0001, "R2 R3 wake set then clear");
    rd('h18, 32'h7FFF_FFFE, "R4 wake inverse readback");
    // R5 / R6 requests
    drive_req(12'h004, 1'b1, "R6 enabled port raises irq");
    rd('h08, 32'h0000_0004, "R5 status follows request");
    drive_req(12'h001, 1'b0, "R6 masked port leaves irq low");
    drive_req(12'h800, 1'b1, "R6 top port enabled");
    drive_req(12'h000, 1'b0, "R5 request withdrawn");
    drive_req(12'hFFF, 1'b1, "R6 all ports");
    rd('h08, 32'h0000_0FFF, "R5 upper status bits zero");
    wr('h10, 32'hFFFF_FFFF);
    chk("R6 clear drops irq", 32'(irq), 32'h0);
    // R7 wake mask has no effect
    wr('h14, 32'hFFFF_FFFF);
    chk("R7 full wake mask, irq stays low", 32'(irq), 32'h0);
    // R8 read-only and unmapped writes
    wr('h08, 32'hFFFF_FFFF);
    wr('h00, 32'hFFFF_FFFF);
    wr('h04, 32'hFFFF_FFFF);
    wr('h1C, 32'hFFFF_FFFF);
    wr('h1000, 32'hFFFF_FFFF);
    rd('h0C, 32'h0, "R8 enable untouched by other writes");
    rd('h00, 32'h0007_0002, "R8 ident unchanged");
    rd('h1C, 32'h0, "R8 hole reads zero");
    rd('h800, 32'h0, "R8 far hole reads zero");
    rd('h1000, 32'h0, "R8 window reads zero");
    chk("R8 irq low", 32'(irq), 32'h0);
    // R9 partial and misaligned
    wr('h0C, 32'h0000_0FFF, 4'b0011);
    wr('h0E, 32'h0000_0FFF);
    rd('h0C, 32'h0, "R9 partial write ignored");
    rd('h00, 32'h0, "R9 partial read zero", 4'b0001);
    rd('h0D, 32'h0, "R9 misaligned read zero");
    // R11 read during write returns old value
    @(negedge clk);
    addr = AW'('h0C); wdata = 32'h0000_0010; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    chk("R11 read same edge as write", rdata, 32'h0);
    @(negedge clk);
    chk("R11 next read sees write", rdata, 32'h0000_0010);
    drive_req(12'h010, 1'b1, "R6 re-enabled port");
    // R10 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10 irq cleared", 32'(irq), 32'h0);
    req = '0;
    rd('h0C, 32'h0, "R10 enable cleared");
    rd('h14, 32'h0, "R10 wake cleared");
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule